// File: doc/BRIEF.md
# Gate Driver Fault and Enable Supervisor

This block decides, every clock, whether the two switching channels of a synchronous buck gate driver may follow their PWM decode. Its inputs are comparator flags that are already digital: supply above the power-on-reset level, a start flag and a stop flag for each of the two supplies (the analog hysteresis arrives as this pair), over-temperature, one flag per switch node above the startup overvoltage level, and the level read back from a shared open-drain enable line.

It drives a per-channel gate-allow bit, a per-channel force-low-side-on bit used to discharge the output after a startup overvoltage, a pull-down request for the shared enable line so that peers see the fault, and a two-bit cause code. A startup overvoltage is latched until supply falls below power-on reset and comes back. Undervoltage and over-temperature faults release by themselves.

Top module: `gate_fault_sup`

## Requirements
- R1: While `porOk` is low, every output (`gateAllow`, `forceLow`, `enPullDown`, `faultCode`) is zero two clock edges after the input change, and the latched and supply state is cleared.
- R2: Supply i (bit 0 VCC, bit 1 VCCP) becomes good when `startOk[i]` is high and stays good until `stopOk[i]` is low; a supply with start low and stop high keeps its previous state.
- R3: While powered and either supply is not good, with no overvoltage or thermal fault, `enPullDown` is 1, `gateAllow` and `forceLow` are 0 and `faultCode` is 2'b10.
- R4: Any `swHigh` bit high while powered and before both supplies are good, including the edge at which they become good, latches an overvoltage fault: `forceLow` is all ones, `gateAllow` all zeros, `enPullDown` 1, `faultCode` 2'b01.
- R5: The overvoltage fault stays latched whatever the supplies, switch nodes or temperature do, and clears only after `porOk` has been low.
- R6: Once both supplies are good, `swHigh` has no effect on any output.
- R7: `overTemp` high while powered gives `enPullDown` 1, `gateAllow` 0, `faultCode` 2'b11; when it returns low, the channels are allowed again without any other action.
- R8: Cause priority is overvoltage, then thermal, then undervoltage.
- R9: With no internal fault, a low `enSense` sets `gateAllow` to 0 while `enPullDown` stays 0 and `faultCode` stays 2'b00; gates are allowed only when `enSense` is high.
- R10: A change of `porOk`, the supply flags, `overTemp` or `swHigh` shows on the outputs two clock edges later; a change of `enSense` shows three edges later.
- R11: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| porOk | input | 1 | Supply above power-on-reset level |
| startOk | input | 2 | Per supply: above undervoltage start threshold (bit 0 VCC, bit 1 VCCP) |
| stopOk | input | 2 | Per supply: above undervoltage stop threshold |
| overTemp | input | 1 | Die over-temperature flag |
| swHigh | input | NCH | Per channel: switch node above startup overvoltage level |
| enSense | input | 1 | Level read back from the shared enable line (asynchronous) |
| gateAllow | output | NCH | Per channel: PWM decode may drive the gates |
| forceLow | output | NCH | Per channel: force low-side gate on for output discharge |
| enPullDown | output | 1 | Request to pull the shared enable line low |
| faultCode | output | 2 | 00 none, 01 startup overvoltage, 10 undervoltage, 11 thermal |

## Verification
The delicate coincidence is a switch node rising in the same cycle that both supplies cross their start threshold: the overvoltage window closes at that edge, yet the latch must still catch the event because its window is judged on the supply state from before the edge. The bench provokes this by raising both start flags and a switch-node flag together straight after a power-on-reset cycle and expects code 01 with forced low sides. A second collision, a latched overvoltage together with over-temperature and undervoltage, is reached in a scrambled sweep of every input combination and is judged against the stated priority.

// File: rtl/gate_fault_sup_pkg.sv
package gate_fault_sup_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_OV   = 2'b01,
    FC_UV   = 2'b10,
    FC_HOT  = 2'b11
  } faultCode_t;

  typedef struct packed {
    logic porQ;
    logic uvAll;
    logic ovLatch;
    logic hotQ;
    logic extEn;
  } supStrobes_t;

endpackage

// File: rtl/gate_fault_sup_ctrl.sv
module gate_fault_sup_ctrl
  import gate_fault_sup_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int NSUP        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            porOk,
  input  logic [NSUP-1:0] startOk,
  input  logic [NSUP-1:0] stopOk,
  input  logic            overTemp,
  input  logic [NCH-1:0]  swHigh,
  input  logic            enSense,
  output supStrobes_t     strobes
);

  logic [NSUP-1:0]        supOk;
  logic [SYNC_STAGES-1:0] enShift;
  logic                   ovLatch;
  logic                   porQ;
  logic                   hotQ;
  logic                   uvAll;

  // Per-supply hysteresis state from the start/stop flag pair
  for (genvar i = 0; i < NSUP; i++) begin : g_sup
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             supOk[i] <= 1'b0;
      else if (!porOk)        supOk[i] <= 1'b0;
      else if (startOk[i])    supOk[i] <= 1'b1;
      else if (!stopOk[i])    supOk[i] <= 1'b0;
    end
  end

  assign uvAll = &supOk;

  // Startup overvoltage latch: window is judged on pre-edge supply state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovLatch <= 1'b0;
    else if (!porOk)   ovLatch <= 1'b0;
    else if (!uvAll && |swHigh) ovLatch <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      porQ    <= 1'b0;
      hotQ    <= 1'b0;
      enShift <= '0;
    end else begin
      porQ    <= porOk;
      hotQ    <= overTemp;
      enShift <= {enShift[SYNC_STAGES-2:0], enSense};
    end
  end

  assign strobes = '{porQ: porQ, uvAll: uvAll, ovLatch: ovLatch,
                     hotQ: hotQ, extEn: enShift[SYNC_STAGES-1]};

  // R5
  ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovLatch) |-> !$past(porOk));

  // R6
  ov_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovLatch) |-> !$past(uvAll));

endmodule

// File: rtl/gate_fault_sup_dp.sv
module gate_fault_sup_dp
  import gate_fault_sup_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  supStrobes_t    strobes,
  output logic [NCH-1:0] gateAllow,
  output logic [NCH-1:0] forceLow,
  output logic           enPullDown,
  output logic [1:0]     faultCode
);

  logic       ovF, hotF, uvF, anyFault, runOk;
  faultCode_t codeNext;

  always_comb begin
    ovF  = strobes.porQ & strobes.ovLatch;
    hotF = strobes.porQ & strobes.hotQ;
    uvF  = strobes.porQ & ~strobes.uvAll;
    anyFault = ovF | hotF | uvF;
    runOk = strobes.porQ & ~anyFault & strobes.extEn;
    if (ovF)       codeNext = FC_OV;
    else if (hotF) codeNext = FC_HOT;
    else if (uvF)  codeNext = FC_UV;
    else           codeNext = FC_NONE;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gateAllow[c] <= 1'b0;
        forceLow[c]  <= 1'b0;
      end else begin
        gateAllow[c] <= runOk;
        forceLow[c]  <= ovF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enPullDown <= 1'b0;
      faultCode  <= FC_NONE;
    end else begin
      enPullDown <= anyFault;
      faultCode  <= codeNext;
    end
  end

  // R4
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateAllow & forceLow) == '0);

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobes.porQ) |-> (gateAllow == '0 && forceLow == '0 && !enPullDown));

  // R9
  pull_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enPullDown |-> gateAllow == '0);

endmodule

// File: rtl/gate_fault_sup.sv
module gate_fault_sup
  import gate_fault_sup_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           porOk,
  input  logic [1:0]     startOk,
  input  logic [1:0]     stopOk,
  input  logic           overTemp,
  input  logic [NCH-1:0] swHigh,
  input  logic           enSense,
  output logic [NCH-1:0] gateAllow,
  output logic [NCH-1:0] forceLow,
  output logic           enPullDown,
  output logic [1:0]     faultCode
);

  localparam int NSUP = 2;

  supStrobes_t strobes;

  gate_fault_sup_ctrl #(.NCH(NCH), .NSUP(NSUP), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .porOk(porOk), .startOk(startOk), .stopOk(stopOk),
    .overTemp(overTemp), .swHigh(swHigh), .enSense(enSense), .strobes(strobes)
  );

  gate_fault_sup_dp #(.NCH(NCH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .gateAllow(gateAllow),
    .forceLow(forceLow), .enPullDown(enPullDown), .faultCode(faultCode)
  );

endmodule

// File: tb/gate_fault_sup_bench.sv
module gate_fault_sup_bench;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           porOk = 1'b0;
  logic [1:0]     startOk = '0, stopOk = '0;
  logic           overTemp = 1'b0;
  logic [NCH-1:0] swHigh = '0;
  logic           enSense = 1'b0;
  logic [NCH-1:0] gateAllow, forceLow;
  logic           enPullDown;
  logic [1:0]     faultCode;

  gate_fault_sup #(.NCH(NCH)) u_gate_fault_sup (
    .clk(clk), .rst_n(rst_n), .porOk(porOk), .startOk(startOk), .stopOk(stopOk),
    .overTemp(overTemp), .swHigh(swHigh), .enSense(enSense), .gateAllow(gateAllow),
    .forceLow(forceLow), .enPullDown(enPullDown), .faultCode(faultCode)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [1:0] mSup = '0;
  logic       mOv = 1'b0;

  // Expected {gateAllow, forceLow, enPullDown, faultCode} from the requirements
  function automatic logic [6:0] expVal();
    logic ov, uvF, hot;
    logic [1:0] code;
    if (!porOk) return '0;
    ov = mOv; hot = overTemp; uvF = ~&mSup;
    code = ov ? 2'b01 : hot ? 2'b11 : uvF ? 2'b10 : 2'b00;
    return {{NCH{~ov & ~hot & ~uvF & enSense}}, {NCH{ov}}, ov | hot | uvF, code};
  endfunction

  function automatic string tagFor();
    if (!porOk) return "R1";
    if (mOv) return "R4/R8";
    if (overTemp) return "R7";
    if (~&mSup) return "R3";
    if (!enSense) return "R9";
    return "R2";
  endfunction

  task automatic check(string req, logic [6:0] exp);
    logic [6:0] got;
    got = {gateAllow, forceLow, enPullDown, faultCode};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic applyVec(logic p, logic [1:0] st, logic [1:0] sp, logic h,
                          logic [NCH-1:0] sw, logic en);
    logic uvOld;
    porOk = p; startOk = st; stopOk = sp; overTemp = h; swHigh = sw; enSense = en;
    uvOld = &mSup;
    if (!p) begin
      mSup = '0; mOv = 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (st[i]) mSup[i] = 1'b1;
        else if (!sp[i]) mSup[i] = 1'b0;
      end
      if (|sw && (!uvOld || !(&mSup))) mOv = 1'b1;
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [6:0] prev;
    repeat (3) @(negedge clk);
    check("R11", '0);
    rst_n = 1'b1;
    applyVec(0, 2'b11, 2'b11, 1, 2'b11, 1); settle();
    check("R1", expVal());

    // Good state, then latency of a thermal fault (R10, R7)
    applyVec(1, 2'b11, 2'b11, 0, 0, 1); settle();
    check("R2", expVal());
    prev = expVal();
    applyVec(1, 2'b00, 2'b11, 1, 0, 1);
    @(negedge clk); check("R10", prev);
    @(negedge clk); check("R10", expVal());
    check("R7", 7'b0000111);
    applyVec(1, 2'b00, 2'b11, 0, 0, 1); settle();
    check("R7", 7'b1100000);

    // Enable line latency and effect (R9, R10)
    prev = expVal();
    applyVec(1, 2'b00, 2'b11, 0, 0, 0);
    repeat (2) @(negedge clk); check("R10", prev);
    @(negedge clk); check("R10", expVal());
    check("R9", 7'b0000000);
    applyVec(1, 2'b00, 2'b11, 0, 0, 1); settle();

    // Switch node ignored once supplies are good (R6)
    applyVec(1, 2'b00, 2'b11, 0, 2'b11, 1); settle();
    check("R6", 7'b1100000);

    // Hysteresis: VCCP stop drops -> undervoltage (R2, R3)
    applyVec(1, 2'b00, 2'b01, 0, 0, 1); settle();
    check("R3", 7'b0000110);
    applyVec(1, 2'b00, 2'b11, 0, 0, 1); settle();
    check("R2", 7'b0000110);
    applyVec(1, 2'b10, 2'b11, 0, 0, 1); settle();
    check("R2", 7'b1100000);

    // Same-edge start and overvoltage (R4), persistence and clear (R5)
    applyVec(0, 0, 0, 0, 0, 1); settle();
    applyVec(1, 2'b11, 2'b11, 0, 2'b01, 1); settle();
    check("R4", 7'b0011101);
    applyVec(1, 2'b11, 2'b11, 1, 0, 1); settle();
    check("R8", 7'b0011101);
    applyVec(1, 2'b00, 2'b00, 0, 0, 1); settle();
    check("R5", 7'b0011101);
    applyVec(0, 0, 0, 0, 0, 1); settle();
    check("R1", 7'b0000000);
    applyVec(1, 2'b00, 2'b11, 1, 0, 1); settle();
    check("R8", 7'b0000111);
    applyVec(1, 2'b00, 2'b11, 0, 0, 1); settle();
    check("R5", 7'b0000110);

    // Scrambled sweep over every input combination
    for (int i = 0; i < 512; i++) begin
      logic [8:0] v;
      v = 9'((i * 173) % 512);
      applyVec(v[8], v[7:6], v[5:4], v[3], v[2:1], v[0]); settle();
      check(tagFor(), expVal());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule